// File: doc/BRIEF.md
# Eight-Slot TDM Audio Framer

This block connects a multichannel audio codec to on-chip sample processing over a time-division multiplexed serial link. It runs directly on the link's bit clock and takes the frame sync from outside. A frame holds eight 32-bit slots, 256 bit periods in all. At the usual rate the bit clock is 12.288 MHz, which gives 48 kHz frames of about 20.8 µs. Each slot carries a 24-bit sample, MSB first, followed by eight zero bits.

On the transmit side the block takes six 24-bit DAC samples in parallel. It latches them at the frame sync and serializes them into six of the eight slots. The two auxiliary slots are sent as zeros. The receive side collects the four ADC channels from their fixed, non-contiguous slots and presents them together, with a one-cycle valid strobe, once the last bit of the frame has arrived. A frame sync that comes too early or too late raises a one-cycle error strobe, and slot counting then starts again from the next sync.

Top module: `tdm_framer`

## Requirements
- R1: A frame sync sampled high at a rising bit-clock edge means that the bit period starting at that edge carries bit 0 of the frame, which is the MSB of slot 1. A frame is 256 bit periods long: 8 slots of 32 bits, numbered 1 to 8.
- R2: Each slot is sent MSB first. DAC channel k (k = 0..5, taken from `tx_dac[24k+23:24k]`) goes to slots 1, 2, 3, 5, 6 and 7 in that order. The 24 sample bits fill bit positions 0..23 of the slot and positions 24..31 are sent as zero.
- R3: The auxiliary slots 4 and 8 are sent as all zeros.
- R4: `tx_dac` is sampled only at the edge where the frame sync is seen. Changing it later has no effect on the frame in progress. `tx_taken` is high for exactly the one bit period after that edge.
- R5: Bits 0..23 of slots 1, 2, 5 and 6 are assembled MSB first into ADC channels L0, L1, R0 and R1. These appear on `rx_adc[24k+23:24k]` for k = 0..3 in that order. All other received bits are ignored.
- R6: `rx_valid` is high for one bit period right after the edge that captures bit 255 of a frame. `rx_adc` changes only together with `rx_valid` and holds its value between strobes.
- R7: A frame sync that arrives while the framer is locked and fewer than 256 bit periods after the previous one pulses `sync_err` for one period. The partial frame is discarded (no `rx_valid`), and counting restarts with the new frame.
- R8: If no frame sync arrives at the edge where the next frame is due, `sync_err` pulses for one period. The completed frame is still delivered. The framer then goes idle: it sends zeros and delivers nothing until the next sync.
- R9: After reset, and while idle, `sdata_out`, `rx_valid`, `sync_err` and `tx_taken` are 0 and `rx_adc` is 0 until the first frame. The first sync after reset or after idle raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, high at the edge that starts a frame |
| sdata_in | input | 1 | Serial receive data from the codec ADCs |
| tx_dac | input | 144 | Six 24-bit DAC samples, channel k at bits 24k+23:24k |
| tx_taken | output | 1 | One-period strobe: `tx_dac` has been latched |
| sdata_out | output | 1 | Serial transmit data to the codec DACs |
| rx_adc | output | 96 | Four 24-bit ADC samples: L0, L1, R0, R1 from low to high |
| rx_valid | output | 1 | One-period strobe: a new `rx_adc` set is present |
| sync_err | output | 1 | One-period strobe: frame sync early or missing |

## Verification
The assertions assume that reset is held for at least one edge before any traffic. They also assume that `fsync` and `sdata_in` are settled at each rising bit-clock edge, because the block samples both directly on the clock it runs from. To respect this, the stimulus changes every input only on the falling edge. It drives the slot and pad positions with random filler and sends frames of 256, 100 and 300 bit periods, so the zero-pad, auxiliary-slot and error-strobe properties are exercised under both on-time and slipped syncs.

// File: rtl/tdm_framer_pkg.sv
// Package tdm_framer_pkg
// Shared slot maps for the TDM framer. The placement of channels in slots
// is fixed by the codec link, so it is expressed here as constant functions.
// Slots are counted from 0 inside the RTL (slot 1 on the link is index 0).
package tdm_framer_pkg;

    // Slot index that carries ADC channel ch (L0, L1, R0, R1).
    function automatic int adc_slot_of(input int ch);
        case (ch)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    // DAC channel carried in slot s, or -1 for an auxiliary (zero) slot.
    function automatic int dac_chan_of(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            4:       return 3;
            5:       return 4;
            6:       return 5;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Module tdm_frame_timer
// Tracks the bit position within the frame from the external frame sync.
// pos_q is the index of the bit period in progress (0 = MSB of slot 1).
// Assumes: clocked by the serial bit clock; fsync sampled at rising edges.
// A sync that is early, or missing at the expected edge, pulses sync_err.
module tdm_frame_timer #(
    parameter  int FRAME_BITS = 256,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [POS_W-1:0] pos_q,
    output logic             locked_q,
    output logic [POS_W-1:0] pos_nxt,
    output logic             locked_nxt,
    output logic             frame_done,
    output logic             sync_err
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic at_last;
    logic err_nxt;

    // Decide the next position, lock state and error from the sync input.
    always_comb begin
        at_last    = (pos_q == LAST_POS);
        frame_done = locked_q && at_last;
        err_nxt    = 1'b0;
        pos_nxt    = pos_q;
        locked_nxt = locked_q;
        if (fsync) begin
            pos_nxt    = '0;
            locked_nxt = 1'b1;
            err_nxt    = locked_q && !at_last;
        end else if (locked_q) begin
            if (at_last) begin
                pos_nxt    = '0;
                locked_nxt = 1'b0;
                err_nxt    = 1'b1;
            end else begin
                pos_nxt = pos_q + POS_W'(1);
            end
        end
    end

    // Register position, lock and error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            locked_q <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            pos_q    <= pos_nxt;
            locked_q <= locked_nxt;
            sync_err <= err_nxt;
        end
    end

    // An error can only be reported by a framer that was locked.
    p_err_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> $past(locked_q))
        else $error("sync_err without prior lock");

    // A sync always leaves the framer locked at the first bit.
    p_sync_locks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (locked_q && pos_q == '0))
        else $error("sync did not restart the frame");

endmodule

// File: rtl/tdm_tx_serializer.sv
// Module tdm_tx_serializer
// Latches the DAC samples at each frame sync and drives one bit per bit
// period, MSB first, with zero padding and zero auxiliary slots.
// Assumes: SLOT_BITS and SLOTS are powers of two, SAMPLE_BITS < SLOT_BITS.
// The output is registered from the look-ahead position of the timer.
module tdm_tx_serializer
    import tdm_framer_pkg::*;
#(
    parameter  int SLOTS       = 8,
    parameter  int SLOT_BITS   = 32,
    parameter  int SAMPLE_BITS = 24,
    parameter  int DAC_CH      = 6,
    localparam int FRAME_BITS  = SLOTS * SLOT_BITS,
    localparam int POS_W       = $clog2(FRAME_BITS),
    localparam int BIT_W       = $clog2(SLOT_BITS),
    localparam int SLOT_W      = $clog2(SLOTS),
    localparam int PAD_BITS    = SLOT_BITS - SAMPLE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync,
    input  logic [DAC_CH*SAMPLE_BITS-1:0] tx_dac,
    input  logic [POS_W-1:0]              pos_q,
    input  logic                          locked_q,
    input  logic [POS_W-1:0]              pos_nxt,
    input  logic                          locked_nxt,
    output logic                          sdata_out,
    output logic                          tx_taken
);

    logic [DAC_CH*SAMPLE_BITS-1:0] hold_q;
    logic [DAC_CH*SAMPLE_BITS-1:0] src;
    logic [SLOTS-1:0][SLOT_BITS-1:0] slot_word;
    logic [SLOT_W-1:0] nxt_slot;
    logic [BIT_W-1:0]  nxt_bit;
    logic              line_bit;

    // At the sync edge the fresh samples feed the first bit directly.
    assign src = fsync ? tx_dac : hold_q;

    // Build each slot word: a DAC sample with zero pad, or all zeros.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int CH = dac_chan_of(s);
        if (CH >= 0 && CH < DAC_CH) begin : g_dac
            assign slot_word[s] = {src[CH*SAMPLE_BITS +: SAMPLE_BITS], {PAD_BITS{1'b0}}};
        end else begin : g_aux
            assign slot_word[s] = '0;
        end
    end

    // Pick the bit for the next period; ~nxt_bit gives MSB-first order.
    always_comb begin
        nxt_slot = pos_nxt[POS_W-1 -: SLOT_W];
        nxt_bit  = pos_nxt[BIT_W-1:0];
        line_bit = slot_word[nxt_slot][~nxt_bit];
    end

    // Latch samples at sync, register the serial bit and the take strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            sdata_out <= 1'b0;
            tx_taken  <= 1'b0;
        end else begin
            if (fsync) begin
                hold_q <= tx_dac;
            end
            sdata_out <= locked_nxt && line_bit;
            tx_taken  <= fsync;
        end
    end

    // Pad positions of every slot carry zero.
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && int'(pos_q[BIT_W-1:0]) >= SAMPLE_BITS) |-> !sdata_out)
        else $error("non-zero pad bit");

    // Auxiliary slots carry zero.
    p_aux_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && dac_chan_of(int'(pos_q[POS_W-1 -: SLOT_W])) < 0) |-> !sdata_out)
        else $error("non-zero auxiliary slot");

    // An idle framer keeps the line low.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_q |-> !sdata_out)
        else $error("line driven while idle");

    // Every sync is answered by the take strobe.
    p_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> tx_taken)
        else $error("tx_taken missing after sync");

endmodule

// File: rtl/tdm_rx_deserializer.sv
// Module tdm_rx_deserializer
// Shifts the sample bits of the ADC slots into one register per channel
// and publishes all channels with a valid strobe when a frame completes.
// Assumes: pos_q/locked_q come from the frame timer on the same clock.
module tdm_rx_deserializer
    import tdm_framer_pkg::*;
#(
    parameter  int SLOTS       = 8,
    parameter  int SLOT_BITS   = 32,
    parameter  int SAMPLE_BITS = 24,
    parameter  int ADC_CH      = 4,
    localparam int FRAME_BITS  = SLOTS * SLOT_BITS,
    localparam int POS_W       = $clog2(FRAME_BITS),
    localparam int BIT_W       = $clog2(SLOT_BITS),
    localparam int SLOT_W      = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sdata_in,
    input  logic [POS_W-1:0]              pos_q,
    input  logic                          locked_q,
    input  logic                          frame_done,
    output logic [ADC_CH*SAMPLE_BITS-1:0] rx_adc,
    output logic                          rx_valid
);

    logic [SLOT_W-1:0] cur_slot;
    logic              in_sample;

    // Decode the current slot and whether the bit belongs to the sample.
    always_comb begin
        cur_slot  = pos_q[POS_W-1 -: SLOT_W];
        in_sample = locked_q && (int'(pos_q[BIT_W-1:0]) < SAMPLE_BITS);
    end

    for (genvar c = 0; c < ADC_CH; c++) begin : g_chan
        localparam int SLOT_IDX = adc_slot_of(c);
        logic [SAMPLE_BITS-1:0] shift_q;
        logic [SAMPLE_BITS-1:0] out_q;

        // Collect this channel's bits MSB first, publish at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shift_q <= '0;
                out_q   <= '0;
            end else begin
                if (in_sample && cur_slot == SLOT_W'(SLOT_IDX)) begin
                    shift_q <= {shift_q[SAMPLE_BITS-2:0], sdata_in};
                end
                if (frame_done) begin
                    out_q <= shift_q;
                end
            end
        end

        assign rx_adc[c*SAMPLE_BITS +: SAMPLE_BITS] = out_q;
    end

    // Valid strobe follows the capture of the last frame bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= frame_done;
        end
    end

    // Frames are long, so two strobes never touch.
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid)
        else $error("rx_valid wider than one cycle");

    // Samples only move together with the strobe.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_adc))
        else $error("rx_adc changed without rx_valid");

endmodule

// File: rtl/tdm_framer.sv
// Module tdm_framer
// Eight-slot TDM audio framer: six 24-bit DAC channels out, four 24-bit
// ADC channels in, 32-bit slots, running on the external bit clock.
// Assumes: clk is the serial bit clock; fsync and sdata_in are stable at
// its rising edge; synchronous active-low reset precedes traffic.
module tdm_framer #(
    parameter  int SLOTS       = 8,
    parameter  int SLOT_BITS   = 32,
    parameter  int SAMPLE_BITS = 24,
    parameter  int DAC_CH      = 6,
    parameter  int ADC_CH      = 4,
    localparam int FRAME_BITS  = SLOTS * SLOT_BITS,
    localparam int POS_W       = $clog2(FRAME_BITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync,
    input  logic                          sdata_in,
    input  logic [DAC_CH*SAMPLE_BITS-1:0] tx_dac,
    output logic                          tx_taken,
    output logic                          sdata_out,
    output logic [ADC_CH*SAMPLE_BITS-1:0] rx_adc,
    output logic                          rx_valid,
    output logic                          sync_err
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nxt;
    logic             locked_q;
    logic             locked_nxt;
    logic             frame_done;

    tdm_frame_timer #(
        .FRAME_BITS (FRAME_BITS)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .pos_q      (pos_q),
        .locked_q   (locked_q),
        .pos_nxt    (pos_nxt),
        .locked_nxt (locked_nxt),
        .frame_done (frame_done),
        .sync_err   (sync_err)
    );

    tdm_tx_serializer #(
        .SLOTS       (SLOTS),
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS),
        .DAC_CH      (DAC_CH)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .tx_dac     (tx_dac),
        .pos_q      (pos_q),
        .locked_q   (locked_q),
        .pos_nxt    (pos_nxt),
        .locked_nxt (locked_nxt),
        .sdata_out  (sdata_out),
        .tx_taken   (tx_taken)
    );

    tdm_rx_deserializer #(
        .SLOTS       (SLOTS),
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS),
        .ADC_CH      (ADC_CH)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata_in   (sdata_in),
        .pos_q      (pos_q),
        .locked_q   (locked_q),
        .frame_done (frame_done),
        .rx_adc     (rx_adc),
        .rx_valid   (rx_valid)
    );

    // A frame is delivered only by a framer that was counting.
    p_valid_from_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(locked_q))
        else $error("rx_valid while not locked");

endmodule

// File: tb/tdm_framer_tb_top.sv
// Scoreboard bench for tdm_framer. The driver task pushes expected ADC
// sets into a queue and predicts line/strobe values per bit period; a
// monitor pops and compares on rx_valid. Inputs change on falling edges.
module tdm_framer_tb_top;

    localparam int SB   = 24;
    localparam int DACN = 6;
    localparam int ADCN = 4;
    localparam int FB   = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic sdata_in = 1'b0;
    logic [DACN*SB-1:0] tx_dac = '0;
    logic tx_taken, sdata_out, rx_valid, sync_err;
    logic [ADCN*SB-1:0] rx_adc;

    always #4 clk = ~clk;

    tdm_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .sdata_in  (sdata_in),
        .tx_dac    (tx_dac),
        .tx_taken  (tx_taken),
        .sdata_out (sdata_out),
        .rx_adc    (rx_adc),
        .rx_valid  (rx_valid),
        .sync_err  (sync_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [143:0] act, input logic [143:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard and reference state.
    logic [ADCN*SB-1:0] rx_q[$];
    bit m_locked = 1'b0;
    int m_pos = 0;
    logic [DACN*SB-1:0] tx_lat = '0;
    logic [FB-1:0] rx_bits = '0;
    bit e_out = 1'b0, e_err = 1'b0, e_taken = 1'b0, chk_on = 1'b0;
    int bad_tx = 0, bad_err = 0, bad_taken = 0;
    bit pend = 1'b0;

    // Slot maps from R2 and R5 (slot index counted from 0).
    function automatic int dac_ch_for(input int s);
        case (s)
            0: return 0; 1: return 1; 2: return 2;
            4: return 3; 5: return 4; 6: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic int adc_slot(input int c);
        case (c)
            0: return 0; 1: return 1; 2: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic tx_bit(input int p);
        int s = p / 32;
        int j = p % 32;
        int c = dac_ch_for(s);
        if (c < 0 || j >= SB) return 1'b0;
        return tx_lat[c*SB + SB-1-j];
    endfunction

    function automatic logic [ADCN*SB-1:0] adc_from_bits();
        logic [ADCN*SB-1:0] v = '0;
        for (int c = 0; c < ADCN; c++)
            for (int j = 0; j < SB; j++)
                v[c*SB + SB-1-j] = rx_bits[adc_slot(c)*32 + j];
        return v;
    endfunction

    // One bit period: compare the previous prediction, drive, predict.
    task automatic drive_edge(input bit fs, input bit d);
        @(negedge clk);
        if (chk_on) begin
            if (sdata_out !== e_out)   bad_tx++;
            if (sync_err !== e_err)    bad_err++;
            if (tx_taken !== e_taken)  bad_taken++;
        end
        fsync    = fs;
        sdata_in = d;
        e_err    = 1'b0;
        if (m_locked) begin
            rx_bits[m_pos] = d;
            if (m_pos == FB-1) rx_q.push_back(adc_from_bits());
        end
        if (fs) begin
            if (m_locked && m_pos != FB-1) e_err = 1'b1;
            m_locked = 1'b1;
            m_pos    = 0;
            tx_lat   = tx_dac;
        end else if (m_locked) begin
            if (m_pos == FB-1) begin
                e_err    = 1'b1;
                m_locked = 1'b0;
            end else begin
                m_pos++;
            end
        end
        e_taken = fs;
        e_out   = m_locked ? tx_bit(m_pos) : 1'b0;
        chk_on  = 1'b1;
    endtask

    // Send a frame of len bit periods; ADC fields overlaid on random filler.
    task automatic send_frame(input int len, input logic [DACN*SB-1:0] dac,
                              input logic [ADCN*SB-1:0] adc);
        logic [FB-1:0] f;
        for (int p = 0; p < FB; p++) f[p] = 1'($urandom % 2);
        for (int c = 0; c < ADCN; c++)
            for (int j = 0; j < SB; j++)
                f[adc_slot(c)*32 + j] = adc[c*SB + SB-1-j];
        tx_dac = dac;
        for (int k = 0; k < len; k++) begin
            logic d;
            if (k == 0)            d = pend;
            else if (k - 1 < FB)   d = f[k-1];
            else                   d = 1'($urandom % 2);
            drive_edge(k == 0, d);
            if (k == 1) tx_dac = ~dac ^ {$urandom, $urandom, $urandom, $urandom, $urandom};
        end
        pend = (len - 1 < FB) ? f[len-1] : 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_edge(1'b0, (i == 0) ? pend : 1'($urandom % 2));
    endtask

    task automatic seg_report(input string t_tx, input string t_err, input string t_tk);
        check(bad_tx == 0, t_tx, bad_tx, 0);
        check(bad_err == 0, t_err, bad_err, 0);
        check(bad_taken == 0, t_tk, bad_taken, 0);
        bad_tx = 0; bad_err = 0; bad_taken = 0;
    endtask

    function automatic logic [DACN*SB-1:0] rnd_dac();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [ADCN*SB-1:0] rnd_adc();
        return {$urandom, $urandom, $urandom};
    endfunction

    // Monitor: pop expected ADC sets on rx_valid, watch hold between strobes.
    logic [ADCN*SB-1:0] last_adc = '0;
    logic [ADCN*SB-1:0] exp_adc;
    int hold_bad = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rx_valid) begin
                if (rx_q.size() == 0) begin
                    check(1'b0, "R6 R7 unexpected rx_valid", 1, 0);
                end else begin
                    exp_adc = rx_q.pop_front();
                    check(rx_adc === exp_adc, "R5 R6 rx samples", rx_adc, exp_adc);
                end
                last_adc = rx_adc;
            end else if (rx_adc !== last_adc) begin
                hold_bad++;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: quiet outputs after reset.
        check(sdata_out === 1'b0 && rx_valid === 1'b0 && sync_err === 1'b0 &&
              tx_taken === 1'b0, "R9 reset strobes", {sdata_out, rx_valid, sync_err, tx_taken}, 0);
        check(rx_adc === '0, "R9 reset rx_adc", rx_adc, 0);

        idle(20);
        seg_report("R9 idle line", "R9 idle err", "R9 idle taken");

        // Main function: on-time frames with several patterns.
        send_frame(FB, '1, '1);
        send_frame(FB, {DACN{24'hA5C3F0}}, {24'h800001, 24'h400002, 24'h000FFF, 24'hFFF000});
        send_frame(FB, '0, '0);
        send_frame(FB, rnd_dac(), rnd_adc());
        send_frame(FB, rnd_dac(), rnd_adc());
        seg_report("R1 R2 R3 serial out", "R1 R9 on-time sync", "R4 take strobe");

        // Early sync: partial frame dropped, error on the next sync.
        send_frame(100, rnd_dac(), rnd_adc());
        send_frame(FB, rnd_dac(), rnd_adc());
        send_frame(FB, '1, rnd_adc());
        seg_report("R7 serial out after slip", "R7 early sync", "R4 take after slip");

        // Late sync: frame delivered, error, idle until next sync.
        send_frame(300, rnd_dac(), rnd_adc());
        send_frame(FB, rnd_dac(), rnd_adc());
        idle(40);
        seg_report("R8 serial out idle after late", "R8 late sync", "R4 take after late");

        check(rx_q.size() == 0, "R5 R6 frames not delivered", rx_q.size(), 0);
        check(hold_bad == 0, "R6 rx_adc hold", hold_bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule